// File: doc/BRIEF.md
# Frame Clock Ratio Guard

This block runs in the PLL output clock domain and checks that an incoming audio frame clock stays in step with that clock. It counts PLL cycles between consecutive rising edges of the frame clock and compares each count with an expected ratio `ratio_n_i`, allowing a tolerance of ±4 cycles. The PLL lock indication is part of the same check. The frame clock is asynchronous, so it passes through a two-flop synchroniser before its edges are used.

A small state machine holds the verdict. It has three states. FAULT means unsynchronised and is the reset state. RECOVER means one good frame has been seen. LOCKED means synchronised. The transitions are:

- FAULT→RECOVER on a good frame.
- RECOVER→LOCKED on a second consecutive good frame.
- RECOVER→FAULT on any failure.
- LOCKED→FAULT on any failure.

A good frame is an evaluated period inside the window while the PLL is locked. A failure is any of three events: a period outside the window, the PLL lock input being low, or the period counter saturating without seeing an edge. When the state is not LOCKED, `sync_err_o` is high. If the detect enable is set, the downstream audio path is also muted and its processing frozen.

Top module: `frame_ratio_guard`

## Requirements
- R1: After reset the state is FAULT. With the detect enable at 1, `mute_o`, `freeze_o` and `sync_err_o` are all 1 before any frame has been measured.
- R2: A measured period P with `ratio_n_i`−4 ≤ P ≤ `ratio_n_i`+4, taken while `pll_locked_i` is 1, counts as a good frame. Both window limits are inclusive.
- R3: A measured period outside that window moves the state to FAULT on the next clock edge.
- R4: When `pll_locked_i` is 0, the state moves to FAULT on the next clock edge, whatever the period count is.
- R5: `mute_o` and `freeze_o` are each equal to (`det_en_i` AND state≠LOCKED). `sync_err_o` is 1 whenever state≠LOCKED, whatever `det_en_i` is.
- R6: Leaving FAULT takes two consecutive good frames. The first goes to RECOVER and the second to LOCKED. A failure while in RECOVER returns to FAULT and restarts the count.
- R7: The period counter saturates at 2^CNT_W−1 and does not wrap. Saturation without a frame-clock edge is a failure. With CNT_W=12, about 4095 PLL cycles without an edge trigger it.
- R8: A measured period equals the number of PLL cycles between two rising edges of the frame clock. The first rising edge after reset only starts measurement and is not judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PLL output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fclk_i | input | 1 | Audio frame clock, asynchronous to clk_i |
| ratio_n_i | input | CNT_W | Expected PLL cycles per frame |
| pll_locked_i | input | 1 | PLL lock indication, 1 = locked |
| det_en_i | input | 1 | Enables muting and freezing on loss of sync |
| mute_o | output | 1 | Mutes PCM data toward processing |
| freeze_o | output | 1 | Freezes active processing tasks |
| sync_err_o | output | 1 | 1 while not synchronised |

## Verification
Four behaviours are checked by assertions on every cycle:

- A low lock input forces the error flag on the next cycle.
- A saturated counter forces the error flag, and the counter stays saturated until an edge arrives.
- A judged out-of-window period forces the error flag.
- LOCKED is entered only from RECOVER, and the enable gates both protective outputs.

Other behaviours can only be shown by the bench's scenarios: the exact inclusive window limits, the measured period matching the frame length in PLL cycles, the first edge being ignored, the restart of the recovery count after an intervening bad frame, and the long idle run that reaches saturation.

// File: rtl/frg_pkg.sv
package frg_pkg;
    typedef enum logic [1:0] {
        ST_FAULT   = 2'd0,
        ST_RECOVER = 2'd1,
        ST_LOCKED  = 2'd2
    } frg_state_e;
endpackage

// File: rtl/frg_edge_sync.sv
// Multi-flop synchroniser followed by a rising-edge detector.
module frg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    // sh_q[STAGES-1] is the last synchroniser flop; sh_q[STAGES] its delayed copy
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/frg_period_cnt.sv
// Counts clock cycles since the last restart; saturates at all-ones.
module frg_period_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [CNT_W-1:0] period_o,
    output logic             sat_o,
    output logic             armed_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q   <= CNT_ONE;
            armed_q <= 1'b1;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q   <= cnt_q + CNT_ONE;
        end
    end

    assign period_o = cnt_q;
    assign sat_o    = (cnt_q == CNT_MAX);
    assign armed_o  = armed_q;
endmodule

// File: rtl/frame_ratio_guard.sv
module frame_ratio_guard
    import frg_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int TOL         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fclk_i,
    input  logic [CNT_W-1:0] ratio_n_i,
    input  logic             pll_locked_i,
    input  logic             det_en_i,
    output logic             mute_o,
    output logic             freeze_o,
    output logic             sync_err_o
);
    localparam int             XW    = CNT_W + 1;
    localparam logic [XW-1:0]  TOL_X = XW'(TOL);

    logic             fclk_rise;
    logic             armed;
    logic             sat;
    logic [CNT_W-1:0] period;

    frg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (fclk_i),
        .rise_o  (fclk_rise)
    );

    frg_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (fclk_rise),
        .period_o  (period),
        .sat_o     (sat),
        .armed_o   (armed)
    );

    // Window test in one extra bit so that N below TOL does not underflow
    logic [XW-1:0] per_x;
    logic [XW-1:0] n_x;
    logic          in_win;
    logic          fail_evt;
    logic          good_evt;

    always_comb begin
        per_x    = {1'b0, period};
        n_x      = {1'b0, ratio_n_i};
        in_win   = ((per_x + TOL_X) >= n_x) && (per_x <= (n_x + TOL_X));
        fail_evt = !pll_locked_i || sat || (fclk_rise && armed && !in_win);
        good_evt = fclk_rise && armed && in_win && pll_locked_i && !sat;
    end

    frg_state_e state_q;
    frg_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAULT: begin
                if (good_evt) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (fail_evt)      state_d = ST_FAULT;
                else if (good_evt) state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (fail_evt) state_d = ST_FAULT;
            end
            default: state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_FAULT;
        else         state_q <= state_d;
    end

    always_comb begin
        sync_err_o = (state_q != ST_LOCKED);
        mute_o     = det_en_i && sync_err_o;
        freeze_o   = det_en_i && sync_err_o;
    end
endmodule

// File: rtl/frg_checker.sv
module frg_checker
    import frg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TOL   = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] ratio_n_i,
    input logic             pll_locked_i,
    input logic             det_en_i,
    input logic             rise,
    input logic             armed,
    input logic             sat,
    input logic [CNT_W-1:0] period,
    input frg_state_e       state,
    input logic             mute_o,
    input logic             freeze_o,
    input logic             sync_err_o
);
    logic outside;
    always_comb
        outside = (int'(period) < int'(ratio_n_i) - TOL) ||
                  (int'(period) > int'(ratio_n_i) + TOL);

    // R4: lock loss reported on the next edge
    p_lock_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pll_locked_i |=> sync_err_o);

    // R3: judged period outside the window reports failure
    p_window_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise && armed && outside) |=> sync_err_o);

    // R7: saturated counter is a failure
    p_sat_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sat |=> sync_err_o);

    // R7: counter does not wrap
    p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sat && !rise) |=> sat);

    // R6: LOCKED only entered from RECOVER
    p_two_good_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state == ST_LOCKED) && ($past(state) != ST_LOCKED)) |-> ($past(state) == ST_RECOVER));

    // R5: enable gates protective outputs
    p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !det_en_i |-> (!mute_o && !freeze_o));
endmodule

bind frame_ratio_guard frg_checker #(.CNT_W(CNT_W), .TOL(TOL)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ratio_n_i    (ratio_n_i),
    .pll_locked_i (pll_locked_i),
    .det_en_i     (det_en_i),
    .rise         (fclk_rise),
    .armed        (armed),
    .sat          (sat),
    .period       (period),
    .state        (state_q),
    .mute_o       (mute_o),
    .freeze_o     (freeze_o),
    .sync_err_o   (sync_err_o)
);

// File: tb/sim_frame_ratio_guard.sv
module sim_frame_ratio_guard;
    localparam int CLK_P = 10;
    localparam int CNT_W = 12;
    localparam int NOM   = 64;

    logic             clk;
    logic             rst_n;
    logic             fclk;
    logic [CNT_W-1:0] ratio_n;
    logic             locked;
    logic             en;
    logic             mute;
    logic             freeze;
    logic             err;

    int checks = 0;
    int errors = 0;

    frame_ratio_guard #(.CNT_W(CNT_W)) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .fclk_i       (fclk),
        .ratio_n_i    (ratio_n),
        .pll_locked_i (locked),
        .det_en_i     (en),
        .mute_o       (mute),
        .freeze_o     (freeze),
        .sync_err_o   (err)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic e_mute, logic e_err);
        checks++;
        if (mute !== e_mute || freeze !== e_mute || err !== e_err) begin
            errors++;
            $display("FAIL %s: actual mute=%b freeze=%b err=%b expected mute=%b freeze=%b err=%b",
                     tag, mute, freeze, err, e_mute, e_mute, e_err);
        end
    endtask

    // Each frame lasts p PLL cycles, rising at its start
    task automatic frames(int p, int n);
        for (int f = 0; f < n; f++)
            for (int i = 0; i < p; i++) begin
                @(negedge clk);
                fclk = (i < p/2);
            end
    endtask

    task automatic idle(int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; fclk = 1'b0; ratio_n = CNT_W'(NOM); locked = 1'b1; en = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 reset state", 1'b1, 1'b1);
    endtask

    task automatic t_first_lock();
        frames(NOM, 2);
        chk("R8 first edge only arms, one good frame", 1'b1, 1'b1);
        frames(NOM, 1);
        chk("R2 two good frames reach lock", 1'b0, 1'b0);
    endtask

    task automatic t_window();
        frames(NOM - 4, 3);
        chk("R2 lower limit N-4 accepted", 1'b0, 1'b0);
        frames(NOM + 4, 3);
        chk("R2 upper limit N+4 accepted", 1'b0, 1'b0);
        frames(NOM - 5, 2);
        chk("R3 N-5 rejected", 1'b1, 1'b1);
        frames(NOM, 4);
        chk("R6 relock after short period", 1'b0, 1'b0);
        frames(NOM + 5, 2);
        chk("R3 N+5 rejected", 1'b1, 1'b1);
        frames(NOM, 4);
        chk("R6 relock after long period", 1'b0, 1'b0);
    endtask

    task automatic t_recover_restart();
        frames(NOM - 5, 2);
        frames(NOM, 1);
        frames(NOM + 6, 1);
        chk("R6 one good frame stays muted", 1'b1, 1'b1);
        frames(NOM, 1);
        frames(NOM, 1);
        chk("R6 bad frame restarts recovery", 1'b1, 1'b1);
        frames(NOM, 1);
        chk("R6 second consecutive good frame locks", 1'b0, 1'b0);
    endtask

    task automatic t_lock_loss();
        idle(5);
        locked = 1'b0;
        idle(2);
        chk("R4 lock loss faults", 1'b1, 1'b1);
        locked = 1'b1;
        frames(NOM, 4);
        chk("R4 relock after lock restored", 1'b0, 1'b0);
    endtask

    task automatic t_enable();
        en = 1'b0;
        locked = 1'b0;
        idle(2);
        chk("R5 disabled: no mute, flag set", 1'b0, 1'b1);
        en = 1'b1;
        idle(1);
        chk("R5 enable applies mute", 1'b1, 1'b1);
        locked = 1'b1;
        frames(NOM, 4);
        chk("R5 relock with enable", 1'b0, 1'b0);
    endtask

    task automatic t_timeout();
        idle(3900);
        chk("R7 before saturation still locked", 1'b0, 1'b0);
        idle(300);
        chk("R7 saturation without edge faults", 1'b1, 1'b1);
        idle(4200);
        chk("R7 counter does not wrap", 1'b1, 1'b1);
        frames(NOM, 4);
        chk("R7 relock after timeout", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_first_lock();
        t_window();
        t_recover_restart();
        t_lock_loss();
        t_enable();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule